// File: doc/BRIEF.md
# Address Window Decoder with Target Attributes

This block sits beside an engine that moves data between memories. For each address the engine issues, it finds out which programmable address window the address falls in. Each window maps an aligned, power-of-two region of the 32-bit space onto one target, such as a memory chip select or an on-chip SRAM. A window is built from three things:

- a base register, which holds the region's upper address bits and an eight-bit target attribute;
- a size register, which holds an address mask counted in 64 KB units;
- an enable bit and a two-bit permission field, both kept in one shared control register.

For each request the block returns, one cycle later, a hit or a miss, the index of the winning window, its attribute byte and its permission bits. It also returns a protection error when the access direction is not permitted, and a forward qualifier that tells the fabric the access may proceed. Software or boot code programs the windows through a plain write port with a combinational read-back.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset, every register reads zero, so no window is enabled and every request reports a miss.
- R2: The control register is at offset 0x00. The base register of window i is at offset 0x08+i, and the size register of window i is at offset 0x10+i. A read returns the full 32-bit value last written to that offset, combinationally from cfg_addr.
- R3: Writes to any other offset have no effect, and reads of such offsets return zero.
- R4: Control bit i enables window i. A disabled window never matches, even when its base and mask cover the address.
- R5: An enabled window i matches when the two 16-bit values below are equal. Size bits [31:16] hold (region size / 64 KB) - 1.
  - (req_addr[31:16] AND NOT size_i[31:16])
  - (base_i[31:16] AND NOT size_i[31:16])
- R6: When several enabled windows match, the window with the lowest index is reported.
- R7: On a hit, res_win is the window index and res_attr is base bits [15:8] of that window. res_perm is control bits {17+2i, 16+2i} of that window.
- R8: When no enabled window matches, the outputs are res_miss=1 and res_hit=0. res_win, res_attr and res_perm are all zero, and res_fwd=0.
- R9: Within the permission field, bit 16+2i grants reads and bit 17+2i grants writes. A hit whose direction (req_wr=1 for a write) lacks its grant raises res_prot_err with res_fwd=0. A permitted hit gives res_fwd=1.
- R10: Results appear exactly one clock after req_vld is sampled high, with res_vld=1. In a cycle where res_vld is low, res_hit, res_miss, res_prot_err and res_fwd are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| req_vld | input | 1 | Address request valid |
| req_addr | input | 32 | Request address |
| req_wr | input | 1 | Request is a write |
| res_vld | output | 1 | Result valid |
| res_hit | output | 1 | An enabled window matched |
| res_miss | output | 1 | No enabled window matched |
| res_prot_err | output | 1 | Hit, but the direction is not permitted |
| res_fwd | output | 1 | Access may be forwarded |
| res_win | output | WIN_W (3) | Winning window index |
| res_attr | output | 8 | Target attribute of the winning window |
| res_perm | output | 2 | Permission field of the winning window |

## Verification
A corrupted base, size or control bit surfaces at the ports in two places. It shows up immediately on cfg_rdata for that offset. It also shows up one cycle after the first request whose upper address bits fall in the affected region, as a wrong window index, a wrong attribute, or a miss where a hit was due. The bench therefore programs overlapping, disabled, read-only and write-only windows, then sweeps upper address bits across the whole space in both directions. Priority mistakes surface only at overlaps, so a dedicated overlapping window exercises them.

// File: rtl/addr_window_pkg.sv
// Package: register layout constants shared by the decoder modules.
// Assumes a 32-bit register port and at most eight windows.
package addr_window_pkg;
    localparam int DATA_W    = 32;
    localparam int REG_AW    = 5;
    localparam int IDX_BITS  = 3;
    localparam int MAX_WIN   = 8;
    localparam int PERM_LSB  = 16;
    localparam int REGION_LSB = 16;
    localparam int ATTR_LSB  = 8;
    localparam int ATTR_W    = 8;
    localparam int PERM_W    = 2;
    localparam int PERM_RD   = 0;
    localparam int PERM_WR   = 1;

    typedef enum logic [1:0] {
        GRP_CTRL = 2'b00,
        GRP_BASE = 2'b01,
        GRP_SIZE = 2'b10,
        GRP_NONE = 2'b11
    } reg_grp_e;
endpackage

// File: rtl/awd_cfg_regs.sv
// Module: configuration register file for the window decoder.
// Holds one control word plus a base and a size word per window.
// Assumes NUM_WIN <= 8. Unmapped offsets drop writes and read zero.
module awd_cfg_regs
    import addr_window_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            we,
    input  logic [REG_AW-1:0]               addr,
    input  logic [DATA_W-1:0]               wdata,
    output logic [DATA_W-1:0]               rdata,
    output logic [DATA_W-1:0]               ctrl_q,
    output logic [NUM_WIN-1:0][DATA_W-1:0]  base_q,
    output logic [NUM_WIN-1:0][DATA_W-1:0]  size_q
);
    reg_grp_e              grp;
    logic [IDX_BITS-1:0]   idx;
    logic                  idx_ok;
    logic                  ctrl_sel;

    // Split the offset into a register group and a window index.
    always_comb begin
        idx      = addr[IDX_BITS-1:0];
        idx_ok   = (32'(idx) < NUM_WIN);
        grp      = reg_grp_e'(addr[REG_AW-1:IDX_BITS]);
        ctrl_sel = (grp == GRP_CTRL) && (idx == '0);
    end

    // Control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (we && ctrl_sel)
            ctrl_q <= wdata;
    end

    // Per-window base and size storage.
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win_reg
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[w] <= '0;
                size_q[w] <= '0;
            end else if (we && (32'(idx) == w)) begin
                if (grp == GRP_BASE) base_q[w] <= wdata;
                if (grp == GRP_SIZE) size_q[w] <= wdata;
            end
        end
    end

    // Combinational read-back multiplexer.
    always_comb begin
        rdata = '0;
        unique case (grp)
            GRP_CTRL: if (ctrl_sel) rdata = ctrl_q;
            GRP_BASE: if (idx_ok)   rdata = base_q[idx];
            GRP_SIZE: if (idx_ok)   rdata = size_q[idx];
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/awd_win_match.sv
// Module: parallel region comparators, one per window.
// Assumes size bits [31:16] hold a mask of don't-care address bits.
module awd_win_match
    import addr_window_pkg::*;
#(
    parameter int NUM_WIN = 8
) (
    input  logic [DATA_W-1:0]               addr,
    input  logic [DATA_W-1:0]               ctrl_q,
    input  logic [NUM_WIN-1:0][DATA_W-1:0]  base_q,
    input  logic [NUM_WIN-1:0][DATA_W-1:0]  size_q,
    output logic [NUM_WIN-1:0]              hit_vec
);
    localparam int RGN_W = DATA_W - REGION_LSB;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        logic [RGN_W-1:0] diff;
        // Compare the unmasked upper bits of the address against the base.
        always_comb begin
            diff       = (addr[DATA_W-1:REGION_LSB] ^ base_q[w][DATA_W-1:REGION_LSB])
                         & ~size_q[w][DATA_W-1:REGION_LSB];
            hit_vec[w] = ctrl_q[w] && (diff == '0);
        end
    end
endmodule

// File: rtl/awd_prio_pick.sv
// Module: lowest-index-wins selector over a hit vector.
// Assumes WIN_W is wide enough to hold NUM_WIN-1.
module awd_prio_pick #(
    parameter int NUM_WIN = 8,
    parameter int WIN_W   = 3
) (
    input  logic [NUM_WIN-1:0] hit_vec,
    output logic               any,
    output logic [WIN_W-1:0]   idx
);
    // Scan from the top down, so the lowest set bit is written last.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                any = 1'b1;
                idx = WIN_W'(w);
            end
        end
    end
endmodule

// File: rtl/addr_window_decoder.sv
// Module: address window decoder top.
// Matches each request against the enabled windows, picks the lowest
// matching index and registers hit/miss, attribute, permission and
// protection results one cycle later. Assumes NUM_WIN <= 8.
module addr_window_decoder
    import addr_window_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [4:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              req_vld,
    input  logic [31:0]       req_addr,
    input  logic              req_wr,
    output logic              res_vld,
    output logic              res_hit,
    output logic              res_miss,
    output logic              res_prot_err,
    output logic              res_fwd,
    output logic [WIN_W-1:0]  res_win,
    output logic [7:0]        res_attr,
    output logic [1:0]        res_perm
);
    logic [DATA_W-1:0]              ctrl_q;
    logic [NUM_WIN-1:0][DATA_W-1:0] base_q;
    logic [NUM_WIN-1:0][DATA_W-1:0] size_q;
    logic [NUM_WIN-1:0]             hit_vec;
    logic                           any_hit;
    logic [WIN_W-1:0]               win_idx;
    logic [ATTR_W-1:0]              attr_d;
    logic [PERM_W-1:0]              perm_d;
    logic                           prot_d;

    awd_cfg_regs #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .ctrl_q (ctrl_q),
        .base_q (base_q),
        .size_q (size_q)
    );

    awd_win_match #(.NUM_WIN(NUM_WIN)) u_match (
        .addr    (req_addr),
        .ctrl_q  (ctrl_q),
        .base_q  (base_q),
        .size_q  (size_q),
        .hit_vec (hit_vec)
    );

    awd_prio_pick #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_pick (
        .hit_vec (hit_vec),
        .any     (any_hit),
        .idx     (win_idx)
    );

    // Fetch the winner's attribute and permission, then judge the direction.
    always_comb begin
        attr_d = '0;
        perm_d = '0;
        if (any_hit) begin
            attr_d = base_q[win_idx][ATTR_LSB +: ATTR_W];
            perm_d = ctrl_q[PERM_LSB + PERM_W * 32'(win_idx) +: PERM_W];
        end
        prot_d = any_hit && (req_wr ? !perm_d[PERM_WR] : !perm_d[PERM_RD]);
    end

    // Result register stage: one cycle from request to answer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_vld      <= 1'b0;
            res_hit      <= 1'b0;
            res_miss     <= 1'b0;
            res_prot_err <= 1'b0;
            res_fwd      <= 1'b0;
            res_win      <= '0;
            res_attr     <= '0;
            res_perm     <= '0;
        end else begin
            res_vld      <= req_vld;
            res_hit      <= req_vld && any_hit;
            res_miss     <= req_vld && !any_hit;
            res_prot_err <= req_vld && prot_d;
            res_fwd      <= req_vld && any_hit && !prot_d;
            res_win      <= req_vld ? win_idx : '0;
            res_attr     <= req_vld ? attr_d  : '0;
            res_perm     <= req_vld ? perm_d  : '0;
        end
    end
endmodule

// File: rtl/addr_window_decoder_chk.sv
// Module: property checker for the window decoder, attached by bind.
// Observes ports only.
module addr_window_decoder_chk #(
    parameter int NUM_WIN = 8,
    parameter int WIN_W   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [4:0]       cfg_addr,
    input logic [31:0]      cfg_wdata,
    input logic [31:0]      cfg_rdata,
    input logic             req_vld,
    input logic             req_wr,
    input logic             res_vld,
    input logic             res_hit,
    input logic             res_miss,
    input logic             res_prot_err,
    input logic             res_fwd,
    input logic [WIN_W-1:0] res_win,
    input logic [7:0]       res_attr,
    input logic [1:0]       res_perm
);
    a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> res_vld);
    a_r10_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !res_vld);
    a_r10_quiet_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld |-> !(res_hit || res_miss || res_prot_err || res_fwd));
    a_r8_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |-> (res_hit ^ res_miss));
    a_r8_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        res_miss |-> (res_attr == 8'h00 && res_perm == 2'b00 && res_win == '0 && !res_fwd));
    a_r9_prot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        res_prot_err |-> (res_hit && !res_fwd));
    a_r9_fwd_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        res_fwd |-> (res_hit && !res_prot_err));
    a_r9_perm_direction: assert property (@(posedge clk) disable iff (!rst_n)
        res_hit |-> (res_prot_err == ($past(req_wr) ? !res_perm[1] : !res_perm[0])));
    a_r2_ctrl_readback: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cfg_we) && $past(cfg_addr) == 5'h00 && cfg_addr == 5'h00 && !cfg_we)
        |-> (cfg_rdata == $past(cfg_wdata)));
endmodule

bind addr_window_decoder addr_window_decoder_chk #(.NUM_WIN(NUM_WIN), .WIN_W(WIN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .req_vld      (req_vld),
    .req_wr       (req_wr),
    .res_vld      (res_vld),
    .res_hit      (res_hit),
    .res_miss     (res_miss),
    .res_prot_err (res_prot_err),
    .res_fwd      (res_fwd),
    .res_win      (res_win),
    .res_attr     (res_attr),
    .res_perm     (res_perm)
);

// File: tb/addr_window_decoder_tb.sv
// Bench: programs several window layouts, sweeps the upper address bits in
// both directions and compares against an arithmetic model of the rules.
module addr_window_decoder_tb;
    localparam int NW = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_vld = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_wr = 1'b0;
    logic        res_vld, res_hit, res_miss, res_prot_err, res_fwd;
    logic [2:0]  res_win;
    logic [7:0]  res_attr;
    logic [1:0]  res_perm;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m_ctrl;
    logic [31:0] m_base [NW];
    logic [31:0] m_size [NW];

    always #2.5 clk = ~clk;

    addr_window_decoder #(.NUM_WIN(NW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_vld(req_vld),
        .req_addr(req_addr), .req_wr(req_wr), .res_vld(res_vld),
        .res_hit(res_hit), .res_miss(res_miss), .res_prot_err(res_prot_err),
        .res_fwd(res_fwd), .res_win(res_win), .res_attr(res_attr),
        .res_perm(res_perm)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reg_rd_chk(input logic [4:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(cfg_rdata === exp, tag, cfg_rdata, exp);
    endtask

    // Program the DUT and mirror it in the bench model (R2 layout).
    task automatic set_ctrl(input logic [31:0] d);
        m_ctrl = d; reg_wr(5'h00, d);
    endtask
    task automatic set_win(input int i, input logic [31:0] b, input logic [31:0] s);
        m_base[i] = b; m_size[i] = s;
        reg_wr(5'(8 + i), b);
        reg_wr(5'(16 + i), s);
    endtask

    // Expected packed result {hit,miss,prot,fwd,win[2:0],perm[1:0],attr[7:0]}.
    function automatic logic [16:0] model(input logic [31:0] a, input bit wr);
        for (int i = 0; i < NW; i++) begin
            if (m_ctrl[i] && (((a[31:16] ^ m_base[i][31:16]) & ~m_size[i][31:16]) == 16'h0)) begin
                logic [1:0] p;
                bit pe;
                p  = m_ctrl[16 + 2*i +: 2];
                pe = wr ? !p[1] : !p[0];
                return {1'b1, 1'b0, pe, !pe, 3'(i), p, m_base[i][15:8]};
            end
        end
        return {1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 2'd0, 8'd0};
    endfunction

    task automatic req_chk(input logic [31:0] a, input bit wr, input string force_tag);
        logic [16:0] e, g;
        string tag;
        @(negedge clk);
        req_vld = 1'b1; req_addr = a; req_wr = wr;
        @(negedge clk);
        e = model(a, wr);
        g = {res_hit, res_miss, res_prot_err, res_fwd, res_win, res_perm, res_attr};
        if (force_tag != "") tag = force_tag;
        else if (e[15]) tag = "R8 miss";
        else if (e[14]) tag = "R9 protection";
        else tag = "R5/R7 hit";
        check(res_vld === 1'b1 && g === e, tag, {15'd0, g}, {15'd0, e});
        req_vld = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired act=running exp=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        m_ctrl = '0;
        for (int i = 0; i < NW; i++) begin m_base[i] = '0; m_size[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every mapped register, and a request misses.
        reg_rd_chk(5'h00, 32'h0, "R1 ctrl reset");
        for (int i = 0; i < NW; i++) begin
            reg_rd_chk(5'(8 + i), 32'h0, "R1 base reset");
            reg_rd_chk(5'(16 + i), 32'h0, "R1 size reset");
        end
        req_chk(32'h0000_0000, 1'b0, "R1 miss after reset");

        // R2 / R3: readback and unmapped offsets.
        reg_wr(5'h00, 32'hA5A5_5A5A);
        reg_rd_chk(5'h00, 32'hA5A5_5A5A, "R2 ctrl readback");
        reg_wr(5'h0B, 32'h1234_5678);
        reg_rd_chk(5'h0B, 32'h1234_5678, "R2 base readback");
        reg_wr(5'h15, 32'hFFFF_FFFF);
        reg_rd_chk(5'h15, 32'hFFFF_FFFF, "R2 size readback");
        for (int u = 1; u < 8; u++) begin
            reg_wr(5'(u), 32'hDEAD_0000 | u);
            reg_rd_chk(5'(u), 32'h0, "R3 unmapped ctrl group");
        end
        for (int u = 24; u < 32; u++) begin
            reg_wr(5'(u), 32'hBEEF_0000 | u);
            reg_rd_chk(5'(u), 32'h0, "R3 unmapped high group");
        end
        reg_rd_chk(5'h00, 32'hA5A5_5A5A, "R3 ctrl untouched");

        // Layout A: four 256 MB chip selects, 1 MB SRAM, overlap, disabled, read-only.
        set_win(0, 32'h0000_0E00, 32'h0FFF_0000);
        set_win(1, 32'h1000_0D00, 32'h0FFF_0000);
        set_win(2, 32'h2000_0B00, 32'h0FFF_0000);
        set_win(3, 32'h3000_0700, 32'h0FFF_0000);
        set_win(4, 32'h4000_1F00, 32'h000F_0000);
        set_win(5, 32'h1000_5500, 32'h0000_0000);
        set_win(6, 32'h6000_6600, 32'h0000_0000);
        set_win(7, 32'h8000_3C00, 32'h7FFF_0000);
        // Enables all but 6; window 2 write-only, window 7 read-only, rest full.
        set_ctrl(32'h0000_00BF | (32'hFFFF << 16) & ~(32'h1 << 20) & ~(32'h2 << 30));
        reg_rd_chk(5'h00, m_ctrl, "R2 ctrl layout A");

        req_chk(32'h1000_0000, 1'b0, "R6 overlap lowest index");
        check(res_win === 3'd1, "R6 winner index", {29'd0, res_win}, 32'd1);
        req_chk(32'h6000_0000, 1'b0, "R4 disabled window ignored");
        req_chk(32'h4000_0000, 1'b1, "R7 sram attribute");
        req_chk(32'h400F_FFFF, 1'b0, "R5 sram top edge");
        req_chk(32'h4010_0000, 1'b0, "R5 sram just past end");
        req_chk(32'h2345_6789, 1'b0, "R9 write-only window read");
        req_chk(32'h2345_6789, 1'b1, "R9 write-only window write");
        req_chk(32'hFFFF_FFFC, 1'b1, "R9 read-only window write");

        // R10: idle cycle after a result reports nothing.
        @(negedge clk);
        check(res_vld === 1'b0 && !res_hit && !res_miss && !res_prot_err && !res_fwd,
              "R10 idle quiet", {28'd0, res_vld, res_hit, res_miss, res_fwd}, 32'd0);

        // Sweep of upper address bits, both directions.
        for (int k = 0; k < 1024; k++) begin
            req_chk({16'(k * 64 + (k % 7)), 16'h1234}, k[0], "");
            req_chk({16'(k * 64 + (k % 7)), 16'h1234}, !k[0], "");
        end

        // Layout B: all windows disabled, same bases: every request misses (R4).
        set_ctrl(32'hFFFF_0000);
        for (int k = 0; k < 64; k++)
            req_chk({16'(k * 1024 + 3), 16'h0}, k[1], "R4 all disabled miss");

        // Layout C: only window 5 (single 64 KB block) enabled, full access.
        set_ctrl(32'h0000_0C20);
        set_ctrl(32'h0C00_0020);
        for (int k = 0; k < 64; k++)
            req_chk(32'h0FFE_0000 + k * 32'h0000_8000, k[0], "");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule